// File: doc/BRIEF.md
# Four-Mode Bitmap Pixel Decoder

This block sits between a display timing generator and the video output of a bitmap display. Each character slot it takes a memory address and a row address from the timing generator and turns them into a video RAM byte address. It fetches two bytes per character, cuts each byte into palette indices in the way the active mode packs them, and drives a 6-bit RGB value every clock. When either sync is active the output goes dark and `blank` is raised. When display enable is low the border colour is shown instead of pixels.

A character slot lasts sixteen clocks, so one clock is one pixel of the finest mode. Coarser modes repeat each pixel for two or four clocks, which keeps a line the same width in every mode. The timing inputs are sampled on the last clock of each slot, marked by `slot_last`. A slot's pixels appear on the output two slots later. A host write port selects a pen, loads colour codes into the sixteen palette entries or the border, and requests a new mode. A mode request waits until the end of a horizontal sync pulse before it takes effect.

Top module: `vidpix_engine`

## Requirements
- R1: In the first clock of a slot `ram_addr` is {ma[13:12], ra[2:0], ma[9:0], 0}, built from the timing inputs sampled at the end of the previous slot. In the second clock it is the same address with bit 0 set.
- R2: Mode 0: each byte gives two 4-bit indices. The left pixel's index bits 3..0 are byte bits 1,5,3,7 and the right pixel's are 0,4,2,6. Each pixel lasts 4 clocks.
- R3: Mode 1: each byte gives four 2-bit indices. Pixel n (0..3, left first) has index {bit(3-n), bit(7-n)}. Each pixel lasts 2 clocks.
- R4: Mode 2: each byte gives eight 1-bit indices, bit 7 first. Each pixel lasts 1 clock.
- R5: Mode 3: each byte gives two 2-bit indices, packed as pixels 0 and 1 of mode 1. Each pixel lasts 4 clocks.
- R6: The byte fetched with address bit 0 clear fills clocks 0..7 of the display slot, and the other byte fills clocks 8..15.
- R7: A mode write (`host_data[7:6]`=2, mode in bits 1:0) only takes effect at the first slot boundary where the displayed hsync goes from 1 to 0.
- R8: While the displayed slot has hsync or vsync set, `blank` is 1 and `rgb` is 0.
- R9: When not in sync and display enable is low, `rgb` is the border colour and `blank` is 0.
- R10: A pen write (`host_data[7:6]`=0) stores `host_data[4:0]` as the pen. A colour write (`host_data[7:6]`=1) goes to the border if pen bit 4 is set, and otherwise to the palette entry given by pen bits 3:0.
- R11: A colour write maps the 5-bit code in `host_data[4:0]` to 2 bits each of R, G and B, packed as R in bits 5:4, G in 3:2 and B in 1:0, using the fixed 32-entry hardware colour table.
- R12: After reset the palette, border and pen are zero, the mode is 2, the output is border-coloured (zero) and not blanked.
- R13: The timing inputs sampled at the end of slot k control the output during slot k+2.
- R14: A host write with `host_data[7:6]`=3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| crtc_ma | input | 14 | Character memory address from the timing generator |
| crtc_ra | input | 3 | Raster row within the character |
| crtc_de | input | 1 | Display enable |
| crtc_hs | input | 1 | Horizontal sync |
| crtc_vs | input | 1 | Vertical sync |
| slot_last | output | 1 | High on the clock where timing inputs are sampled |
| ram_addr | output | 16 | Video RAM byte address |
| ram_data | input | 8 | Byte read from video RAM at `ram_addr` (same cycle) |
| host_wr | input | 1 | Host write strobe |
| host_data | input | 8 | Host write data: bits 7:6 operation, low bits payload |
| rgb | output | 6 | Output colour, R 5:4, G 3:2, B 1:0 |
| blank | output | 1 | High during sync |

## Verification
The bench aims at the bit interleaving of each mode with random bytes. A decoder with one swapped bit pair shows the wrong palette entry for some pixel within a few slots. It writes modes in the middle of a line and checks that the old mode stays in use until an hsync pulse ends; a design that switches at once, or at the start of hsync, paints whole slots in the wrong packing. Pen values with bit 4 set check that border writes leave the palette alone. Operation-3 writes are checked by making sure the following pixels and border still match the unchanged model.

// File: rtl/vidpix_pkg.sv
package vidpix_pkg;

  localparam int MA_W           = 14;
  localparam int RA_W           = 3;
  localparam int VA_W           = 16;
  localparam int BYTE_W         = 8;
  localparam int CODE_W         = 5;
  localparam int RGB_W          = 6;
  localparam int IDX_W          = 4;
  localparam int PAL_N          = 1 << IDX_W;
  localparam int BYTES_PER_CHAR = 2;
  localparam int PIX_PER_BYTE   = 8;
  localparam int SLOT_LEN       = BYTES_PER_CHAR * PIX_PER_BYTE;
  localparam int PH_W           = $clog2(SLOT_LEN);
  localparam int FB_W           = BYTES_PER_CHAR * BYTE_W;

  typedef enum logic [1:0] {
    VM_QUAD = 2'd0,
    VM_DUO  = 2'd1,
    VM_MONO = 2'd2,
    VM_PAIR = 2'd3
  } vmode_e;

  typedef enum logic [1:0] {
    OP_PEN  = 2'd0,
    OP_INK  = 2'd1,
    OP_MODE = 2'd2,
    OP_NONE = 2'd3
  } hop_e;

  typedef struct packed {
    logic [MA_W-1:0] ma;
    logic [RA_W-1:0] ra;
    logic            de;
    logic            hs;
    logic            vs;
  } tslot_t;

  // RAM byte address: upper page bits, row, low address bits, half select
  function automatic logic [VA_W-1:0] vram_addr(input logic [MA_W-1:0] ma,
                                                input logic [RA_W-1:0] ra,
                                                input logic            half);
    return {ma[13:12], ra, ma[9:0], half};
  endfunction

  function automatic logic [RGB_W-1:0] pk(input logic [1:0] r,
                                          input logic [1:0] g,
                                          input logic [1:0] b);
    return {r, g, b};
  endfunction

  // hardware colour code to 2:2:2 RGB
  function automatic logic [RGB_W-1:0] code_to_rgb(input logic [CODE_W-1:0] code);
    logic [RGB_W-1:0] c;
    case (code)
      5'd0, 5'd1:   c = pk(2'd1, 2'd1, 2'd1);
      5'd2, 5'd17:  c = pk(2'd0, 2'd2, 2'd1);
      5'd3, 5'd9:   c = pk(2'd2, 2'd2, 2'd1);
      5'd4, 5'd16:  c = pk(2'd0, 2'd0, 2'd1);
      5'd5, 5'd8:   c = pk(2'd2, 2'd0, 2'd1);
      5'd6:         c = pk(2'd0, 2'd1, 2'd1);
      5'd7, 5'd15:  c = pk(2'd2, 2'd1, 2'd1);
      5'd10:        c = pk(2'd2, 2'd2, 2'd0);
      5'd11:        c = pk(2'd2, 2'd2, 2'd2);
      5'd12:        c = pk(2'd2, 2'd0, 2'd0);
      5'd13:        c = pk(2'd2, 2'd0, 2'd2);
      5'd14:        c = pk(2'd2, 2'd1, 2'd0);
      5'd18:        c = pk(2'd0, 2'd2, 2'd0);
      5'd19:        c = pk(2'd0, 2'd2, 2'd2);
      5'd20:        c = pk(2'd0, 2'd0, 2'd0);
      5'd21:        c = pk(2'd0, 2'd0, 2'd2);
      5'd22:        c = pk(2'd0, 2'd1, 2'd0);
      5'd23:        c = pk(2'd0, 2'd1, 2'd2);
      5'd24:        c = pk(2'd1, 2'd0, 2'd1);
      5'd25:        c = pk(2'd1, 2'd2, 2'd1);
      5'd26:        c = pk(2'd1, 2'd2, 2'd0);
      5'd27:        c = pk(2'd1, 2'd2, 2'd2);
      5'd28:        c = pk(2'd1, 2'd0, 2'd0);
      5'd29:        c = pk(2'd1, 2'd0, 2'd2);
      5'd30:        c = pk(2'd1, 2'd1, 2'd0);
      default:      c = pk(2'd1, 2'd1, 2'd2);
    endcase
    return c;
  endfunction

  // palette index for the pixel shown at sub-position sub (0..7) of a byte
  function automatic logic [IDX_W-1:0] pixel_index(input vmode_e            m,
                                                   input logic [BYTE_W-1:0] b,
                                                   input logic [2:0]        sub);
    logic [IDX_W-1:0] idx;
    case (m)
      VM_QUAD: idx = sub[2] ? {b[0], b[4], b[2], b[6]} : {b[1], b[5], b[3], b[7]};
      VM_DUO: begin
        case (sub[2:1])
          2'd0:    idx = {2'b00, b[3], b[7]};
          2'd1:    idx = {2'b00, b[2], b[6]};
          2'd2:    idx = {2'b00, b[1], b[5]};
          default: idx = {2'b00, b[0], b[4]};
        endcase
      end
      VM_MONO: idx = {3'b000, b[3'd7 - sub]};
      default: idx = sub[2] ? {2'b00, b[2], b[6]} : {2'b00, b[3], b[7]};
    endcase
    return idx;
  endfunction

endpackage

// File: rtl/vidpix_fetch.sv
module vidpix_fetch
  import vidpix_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  tslot_t          slot_in,
  input  logic [BYTE_W-1:0] ram_data,
  output logic [VA_W-1:0] ram_addr,
  output logic [PH_W-1:0] phase,
  output logic            slot_end,
  output tslot_t          shown,
  output logic [FB_W-1:0] shown_bytes,
  output logic            hs_fall
);

  logic [PH_W-1:0] ph_q;
  tslot_t          held_q;
  tslot_t          shown_q;
  logic [FB_W-1:0] fetch_q;
  logic [FB_W-1:0] bytes_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_q + 1'b1;
  end

  assign slot_end = (ph_q == PH_W'(SLOT_LEN - 1));
  assign ram_addr = vram_addr(held_q.ma, held_q.ra, ph_q[0]);

  // one capture register per byte of the character
  for (genvar gi = 0; gi < BYTES_PER_CHAR; gi++) begin : g_fetch
    always_ff @(posedge clk) begin
      if (!rst_n)
        fetch_q[gi*BYTE_W +: BYTE_W] <= '0;
      else if (ph_q == PH_W'(gi))
        fetch_q[gi*BYTE_W +: BYTE_W] <= ram_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q  <= '0;
      shown_q <= '0;
      bytes_q <= '0;
    end else if (slot_end) begin
      held_q  <= slot_in;
      shown_q <= held_q;
      bytes_q <= fetch_q;
    end
  end

  assign hs_fall     = slot_end & shown_q.hs & ~held_q.hs;
  assign phase       = ph_q;
  assign shown       = shown_q;
  assign shown_bytes = bytes_q;

endmodule

// File: rtl/vidpix_hostregs.sv
module vidpix_hostregs
  import vidpix_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   host_wr,
  input  logic [7:0]             host_data,
  input  logic                   hs_fall,
  output vmode_e                 mode_act,
  output logic [PAL_N*RGB_W-1:0] pal_flat,
  output logic [RGB_W-1:0]       border,
  output logic                   pal_wr,
  output logic                   border_wr
);

  hop_e              op;
  logic [CODE_W-1:0] pen_q;
  vmode_e            pend_q;
  vmode_e            act_q;
  logic [RGB_W-1:0]  border_q;
  logic [RGB_W-1:0]  rgb_new;
  logic              ink_wr;

  assign op        = hop_e'(host_data[7:6]);
  assign ink_wr    = host_wr && (op == OP_INK);
  assign border_wr = ink_wr &  pen_q[CODE_W-1];
  assign pal_wr    = ink_wr & ~pen_q[CODE_W-1];
  assign rgb_new   = code_to_rgb(host_data[CODE_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pen_q    <= '0;
      pend_q   <= VM_MONO;
      act_q    <= VM_MONO;
      border_q <= '0;
    end else begin
      if (host_wr && op == OP_PEN)  pen_q  <= host_data[CODE_W-1:0];
      if (host_wr && op == OP_MODE) pend_q <= vmode_e'(host_data[1:0]);
      if (border_wr)                border_q <= rgb_new;
      if (hs_fall)                  act_q  <= pend_q;
    end
  end

  for (genvar gp = 0; gp < PAL_N; gp++) begin : g_pal
    logic [RGB_W-1:0] ent_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        ent_q <= '0;
      else if (pal_wr && pen_q[IDX_W-1:0] == IDX_W'(gp))
        ent_q <= rgb_new;
    end
    assign pal_flat[gp*RGB_W +: RGB_W] = ent_q;
  end

  assign mode_act = act_q;
  assign border   = border_q;

endmodule

// File: rtl/vidpix_pixel.sv
module vidpix_pixel
  import vidpix_pkg::*;
(
  input  vmode_e                 mode,
  input  logic [PH_W-1:0]        phase,
  input  tslot_t                 shown,
  input  logic [FB_W-1:0]        shown_bytes,
  input  logic [PAL_N*RGB_W-1:0] pal_flat,
  input  logic [RGB_W-1:0]       border,
  output logic [RGB_W-1:0]       rgb,
  output logic                   blank
);

  logic [BYTE_W-1:0] cur_byte;
  logic [IDX_W-1:0]  idx;
  logic [RGB_W-1:0]  ink;

  // upper phase bit picks the byte, the rest the position inside it
  assign cur_byte = phase[PH_W-1] ? shown_bytes[BYTE_W +: BYTE_W]
                                  : shown_bytes[0 +: BYTE_W];
  assign idx      = pixel_index(mode, cur_byte, phase[2:0]);
  assign ink      = pal_flat[idx*RGB_W +: RGB_W];

  always_comb begin
    blank = shown.hs | shown.vs;
    if (blank)          rgb = '0;
    else if (!shown.de) rgb = border;
    else                rgb = ink;
  end

endmodule

// File: rtl/vidpix_engine.sv
module vidpix_engine
  import vidpix_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [13:0] crtc_ma,
  input  logic [2:0]  crtc_ra,
  input  logic        crtc_de,
  input  logic        crtc_hs,
  input  logic        crtc_vs,
  output logic        slot_last,
  output logic [15:0] ram_addr,
  input  logic [7:0]  ram_data,
  input  logic        host_wr,
  input  logic [7:0]  host_data,
  output logic [5:0]  rgb,
  output logic        blank
);

  tslot_t                 slot_in_w;
  tslot_t                 shown_w;
  logic [PH_W-1:0]        phase_w;
  logic [FB_W-1:0]        bytes_w;
  logic                   hs_fall_w;
  vmode_e                 mode_act_w;
  logic [PAL_N*RGB_W-1:0] pal_w;
  logic [RGB_W-1:0]       border_w;
  logic                   pal_wr_w;
  logic                   border_wr_w;
  logic                   shown_de_w;

  assign slot_in_w  = {crtc_ma, crtc_ra, crtc_de, crtc_hs, crtc_vs};
  assign shown_de_w = shown_w.de;

  vidpix_fetch u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .slot_in     (slot_in_w),
    .ram_data    (ram_data),
    .ram_addr    (ram_addr),
    .phase       (phase_w),
    .slot_end    (slot_last),
    .shown       (shown_w),
    .shown_bytes (bytes_w),
    .hs_fall     (hs_fall_w)
  );

  vidpix_hostregs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_wr   (host_wr),
    .host_data (host_data),
    .hs_fall   (hs_fall_w),
    .mode_act  (mode_act_w),
    .pal_flat  (pal_w),
    .border    (border_w),
    .pal_wr    (pal_wr_w),
    .border_wr (border_wr_w)
  );

  vidpix_pixel u_pixel (
    .mode        (mode_act_w),
    .phase       (phase_w),
    .shown       (shown_w),
    .shown_bytes (bytes_w),
    .pal_flat    (pal_w),
    .border      (border_w),
    .rgb         (rgb),
    .blank       (blank)
  );

endmodule

// File: rtl/vidpix_engine_chk.sv
module vidpix_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  phase,
  input logic [15:0] ram_addr,
  input logic        hs_fall,
  input logic [1:0]  mode_act,
  input logic        shown_de,
  input logic [5:0]  border,
  input logic        pal_wr,
  input logic [5:0]  rgb,
  input logic        blank
);

  AST_ADDR_EVEN_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 4'd0) |-> !ram_addr[0]) else $error("even half address"); // R1

  AST_ADDR_ODD_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 4'd1) |-> (ram_addr[0] && ram_addr[15:1] == $past(ram_addr[15:1])))
    else $error("odd half address"); // R1

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_fall |=> $stable(mode_act)) else $error("mode moved off hsync end"); // R7

  AST_SYNC_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> (rgb == 6'd0)) else $error("colour during sync"); // R8

  AST_BORDER_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank && !shown_de) |-> (rgb == border)) else $error("border expected"); // R9

  AST_PAL_KEEPS_BORDER: assert property (@(posedge clk) disable iff (!rst_n)
    pal_wr |=> $stable(border)) else $error("palette write hit border"); // R10

endmodule

bind vidpix_engine vidpix_engine_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .phase    (phase_w),
  .ram_addr (ram_addr),
  .hs_fall  (hs_fall_w),
  .mode_act (mode_act_w),
  .shown_de (shown_de_w),
  .border   (border_w),
  .pal_wr   (pal_wr_w),
  .rgb      (rgb),
  .blank    (blank)
);

// File: tb/vidpix_engine_tb_top.sv
module vidpix_engine_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int RAND_SLOTS = 500;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] crtc_ma = '0;
  logic [2:0]  crtc_ra = '0;
  logic        crtc_de = 1'b0, crtc_hs = 1'b0, crtc_vs = 1'b0;
  logic        slot_last;
  logic [15:0] ram_addr;
  logic [7:0]  ram_data;
  logic        host_wr = 1'b0;
  logic [7:0]  host_data = '0;
  logic [5:0]  rgb;
  logic        blank;

  logic [7:0] mem [65536];
  assign ram_data = mem[ram_addr];

  always #(CLK_PERIOD/2) clk = ~clk;

  vidpix_engine dut_i (.*);

  int    checks = 0;
  int    bad = 0;
  bit    done = 0;
  string sect = "reset";

  // colour table as r,g,b digit triples, stride 4
  string codes = {"111 111 021 221 001 201 011 211 ",
                  "201 221 220 222 200 202 210 211 ",
                  "001 021 020 022 000 002 010 012 ",
                  "101 121 120 122 100 102 110 112 "};

  typedef struct {int ma; int ra; int de; int hs; int vs;} hist_t;
  hist_t h0, h1, h2;
  int pal_m [16];
  int bdr_m, pen_m, pend_m, act_m;

  function automatic int code_rgb(int c);
    int r = codes[4*c] - "0";
    int g = codes[4*c+1] - "0";
    int b = codes[4*c+2] - "0";
    return r*16 + g*4 + b;
  endfunction

  function automatic int addr_of(hist_t h, int c);
    return ((h.ma >> 12) & 3) * 16384 + (h.ra & 7) * 2048 + (h.ma & 1023) * 2 + c;
  endfunction

  function automatic int bt(int v, int k);
    return (v >> k) & 1;
  endfunction

  function automatic int pick(int m, int v, int p);
    int n;
    case (m)
      0: begin n = (p >> 2) & 1; return bt(v,1-n)*8 + bt(v,5-n)*4 + bt(v,3-n)*2 + bt(v,7-n); end
      1: begin n = (p >> 1) & 3; return bt(v,3-n)*2 + bt(v,7-n); end
      2: begin n = p & 7; return bt(v,7-n); end
      default: begin n = (p >> 2) & 1; return bt(v,3-n)*2 + bt(v,7-n); end
    endcase
  endfunction

  function automatic string mode_tag(int m);
    case (m)
      0: return "R2 R6 R13";
      1: return "R3 R6 R13";
      2: return "R4 R6 R13";
      default: return "R5 R6 R13";
    endcase
  endfunction

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s [%s]: got %0d expected %0d", req, sect, got, exp);
    end
  endtask

  task automatic apply_write(int d);
    case ((d >> 6) & 3)
      0: pen_m = d & 31;
      1: if (pen_m & 16) bdr_m = code_rgb(d & 31);
         else pal_m[pen_m & 15] = code_rgb(d & 31);
      2: pend_m = d & 3;
      default: ; // R14 no effect
    endcase
  endtask

  // entered at the negedge of the first clock of a slot
  task automatic do_slot(int ma, int ra, int de, int hs, int vs, int wr, int wd);
    int prev_hs = h2.hs;
    h2 = h1;
    h1 = h0;
    h0 = '{ma, ra, de, hs, vs};
    if (prev_hs != 0 && h2.hs == 0) act_m = pend_m; // R7
    crtc_ma = 14'(ma); crtc_ra = 3'(ra);
    crtc_de = 1'(de);  crtc_hs = 1'(hs); crtc_vs = 1'(vs);
    for (int p = 0; p < 16; p++) begin
      if (p == 1 && wr != 0) apply_write(wd);
      if (p < 2) chk("R1", int'(ram_addr), addr_of(h1, p));
      if (h2.hs != 0 || h2.vs != 0) begin
        chk("R8", int'(blank), 1);
        chk("R8", int'(rgb), 0);
      end else if (h2.de == 0) begin
        chk("R9", int'(blank), 0);
        chk("R9 R10 R11", int'(rgb), bdr_m);
      end else begin
        int v = mem[addr_of(h2, p >> 3)];
        chk("R8", int'(blank), 0);
        chk(mode_tag(act_m), int'(rgb), pal_m[pick(act_m, v, p)]);
      end
      if (p == 0) begin host_wr = 1'(wr); host_data = 8'(wd); end
      else host_wr = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic show(int n, int hs_last);
    for (int i = 0; i < n; i++)
      do_slot($urandom & 16'h3fff, $urandom & 7, 1, 0, 0, 0, 0);
    if (hs_last != 0) do_slot(0, 0, 1, 1, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed = $urandom(32'd20250611);
    for (int a = 0; a < 65536; a++) mem[a] = 8'($urandom);
    h0 = '{0,0,0,0,0}; h1 = h0; h2 = h0;
    for (int i = 0; i < 16; i++) pal_m[i] = 0;
    bdr_m = 0; pen_m = 0; pend_m = 2; act_m = 2;

    repeat (3) @(negedge clk);
    chk("R12", int'(rgb), 0);
    chk("R12", int'(blank), 0);
    chk("R12", int'(ram_addr), 0);
    rst_n = 1'b1;

    // palette and border loading through pen selection
    sect = "R10 R11 load";
    for (int i = 0; i < 16; i++) begin
      do_slot(0, 0, 0, 0, 0, 1, i);
      do_slot(0, 0, 0, 0, 0, 1, 64 | ((i * 7 + 3) % 32));
    end
    do_slot(0, 0, 0, 0, 0, 1, 16);
    do_slot(0, 0, 0, 0, 0, 1, 64 | 13);
    do_slot(0, 0, 0, 0, 0, 1, 31);
    do_slot(0, 0, 0, 0, 0, 1, 64 | 27);
    do_slot(0, 0, 0, 0, 0, 0, 0);
    do_slot(0, 0, 0, 0, 0, 0, 0);

    sect = "R12 reset mode";
    show(6, 0);

    // pending mode requests, each followed by display before and after hsync
    foreach (codes[k]) if (k < 4) begin
      int m = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 3 : 2;
      sect = "R7 pending";
      do_slot($urandom & 16'h3fff, 0, 1, 0, 0, 1, 128 | m);
      show(5, 1);
      sect = "R7 after hsync";
      show(8, 0);
    end

    sect = "R7 vsync only";
    do_slot(5, 1, 1, 0, 0, 1, 128);
    do_slot(0, 0, 1, 0, 1, 0, 0);
    show(6, 0);
    show(0, 1);
    show(4, 0);

    sect = "R14 ignored";
    for (int i = 0; i < 8; i++)
      do_slot($urandom & 16'h3fff, $urandom & 7, i & 1, 0, 0, 1, 192 | ($urandom & 63));
    show(4, 0);

    sect = "R8 sync";
    do_slot(1, 2, 1, 1, 0, 0, 0);
    do_slot(1, 2, 1, 0, 1, 0, 0);
    do_slot(1, 2, 0, 1, 1, 0, 0);
    show(4, 0);

    sect = "random";
    for (int i = 0; i < RAND_SLOTS; i++)
      do_slot($urandom & 16'h3fff, $urandom & 7, ($urandom % 5) != 0,
              ($urandom % 8) == 0, ($urandom % 16) == 0,
              ($urandom % 3) == 0, $urandom & 255);

    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule